// File: doc/BRIEF.md
# Pseudoternary Line Codec with Balancing

This block turns a serial 192 kbit/s subscriber-bus bit stream into three-level line symbols, and watches a received symbol stream for polarity errors. On the transmit side, each bit comes with a two-bit tag that says whether it is ordinary data, the frame-start bit or a balancing bit. A frame assembler outside the block supplies these tags. Binary zeros go out as marks and binary ones as spaces. Successive marks normally alternate in polarity.

The encoder puts a polarity violation on the line in two places. The first is the frame-start bit. The second is the first data mark after the balancing bit that follows it. A receiver can find the frame boundary from these two violations. A balancing bit becomes a mark or a space according to the parity of the marks sent since the previous balancing bit, which keeps the line free of DC. The receive checker flags any mark that repeats the polarity of the mark before it. The two directions share only the clock and the reset. The asynchronous reset input is released through a synchronizer inside the block.

Top module: `ptc_line_codec`

## Requirements
- R1: While reset is asserted, and after it is released, `tx_sym` is space (00) and `rx_viol` is low. After reset, the first mark the encoder sends on a data zero is positive (01), because parameter FIRST_POS defaults to 1.
- R2: The symbol code is 00 for space, 01 for a positive mark and 10 for a negative mark; 11 is never sent. A data bit (tag 00) of value one gives a space. A data bit of value zero gives a mark whose polarity is the opposite of the previous mark.
- R3: A frame-start bit (tag 01) is always sent as a mark with the same polarity as the previous mark. The value on `tx_bit` has no effect on it.
- R4: A balancing bit (tag 10) is a mark, of the opposite polarity to the previous mark, when an odd number of marks has been sent since the previous balancing bit. It is a space when that number is even. The count includes data, frame-start and violation marks, and it restarts after each balancing bit.
- R5: After a balancing bit that follows a frame-start bit, the next data zero is sent with the same polarity as the previous mark. Data ones sent before it do not use up this violation, and only that one mark violates.
- R6: If a second balancing bit arrives before any data zero and no frame-start bit came between the two, the pending violation of R5 is cancelled.
- R7: Tag 11 is encoded exactly like a data bit (tag 00).
- R8: `tx_sym` changes on the clock edge that samples `bit_en` high, one cycle after the inputs are presented. While `bit_en` is low, `tx_sym` and all encoder state hold.
- R9: On a clock edge with `rx_en` high, a received mark with the same polarity as the most recent received mark raises `rx_viol`, which stays high until the next `rx_en` edge. The first mark after reset is never flagged.
- R10: A received space (00), or the unused code 11, clears `rx_viol` at its `rx_en` edge. It does not change the polarity remembered for the next mark.
- R11: While `rx_en` is low, `rx_viol` and the checker state hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Transmit bit-time enable |
| tx_bit | input | 1 | Transmit bit value |
| tx_tag | input | 2 | Bit kind: 00 data, 01 frame-start, 10 balancing, 11 treated as data |
| tx_sym | output | 2 | Line symbol: 00 space, 01 positive mark, 10 negative mark |
| rx_en | input | 1 | Receive symbol-time enable |
| rx_sym | input | 2 | Received line symbol, same code as `tx_sym` |
| rx_viol | output | 1 | Same-polarity mark detected in the current receive bit time |

## Verification
The bench uses the default parameters: FIRST_POS = 1, which makes the first mark after reset positive, and RST_STAGES = 2 for the reset synchronizer. With these values the absolute polarity of every expected symbol is known from reset onward. The stimulus sequence includes two full frame-start and balancing cycles, both values on a frame-start bit, reserved tags, a cancelled pending violation, and balancing bits with both odd and even counts. The encoder's expected output is fed into the checker in the same cycle, so the violations the encoder places on purpose appear as checker flags. A reset in mid-stream then shows that the polarity state really returns to its start value.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int SYM_W = 2;
  localparam int TAG_W = 2;

  typedef enum logic [SYM_W-1:0] {
    SYM_SPACE = 2'b00,
    SYM_POS   = 2'b01,
    SYM_NEG   = 2'b10,
    SYM_BAD   = 2'b11
  } sym_e;

  typedef enum logic [TAG_W-1:0] {
    TAG_DATA  = 2'b00,
    TAG_FRAME = 2'b01,
    TAG_BAL   = 2'b10,
    TAG_RSVD  = 2'b11
  } tag_e;

  function automatic logic [SYM_W-1:0] mark_of(input logic neg);
    return neg ? SYM_NEG : SYM_POS;
  endfunction
endpackage

// File: rtl/ptc_tx_encoder.sv
module ptc_tx_encoder
  import ptc_pkg::*;
#(
  parameter bit FIRST_POS = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             tx_bit,
  input  logic [TAG_W-1:0] tx_tag,
  output logic [SYM_W-1:0] tx_sym
);
  typedef struct packed {
    logic             last_neg;
    logic             par_odd;
    logic             frame_seen;
    logic             viol_due;
    logic [SYM_W-1:0] sym;
  } enc_st_t;

  enc_st_t q, d;
  logic    mark;
  logic    mark_neg;

  always_comb begin
    d        = q;
    mark     = 1'b0;
    mark_neg = ~q.last_neg;
    if (bit_en) begin
      case (tx_tag)
        TAG_FRAME: begin
          mark         = 1'b1;
          mark_neg     = q.last_neg;       // forced violation
          d.frame_seen = 1'b1;
          d.viol_due   = 1'b0;
        end
        TAG_BAL: begin
          mark         = q.par_odd;
          d.viol_due   = q.frame_seen;     // arm or cancel
          d.frame_seen = 1'b0;
        end
        default: begin                     // data and reserved tag
          mark = ~tx_bit;
          if (q.viol_due) mark_neg = q.last_neg;
          if (~tx_bit) d.viol_due = 1'b0;
        end
      endcase
      d.sym = mark ? mark_of(mark_neg) : SYM_SPACE;
      if (mark) d.last_neg = mark_neg;
      d.par_odd = (tx_tag == TAG_BAL) ? 1'b0 : (q.par_odd ^ mark);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.last_neg   <= FIRST_POS;
      q.par_odd    <= 1'b0;
      q.frame_seen <= 1'b0;
      q.viol_due   <= 1'b0;
      q.sym        <= SYM_SPACE;
    end else begin
      q <= d;
    end
  end

  assign tx_sym = q.sym;

  p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sym != SYM_BAD);
  p_one_is_space_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && (tx_tag == TAG_DATA) && tx_bit |=> tx_sym == SYM_SPACE);
  p_frame_is_mark_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && (tx_tag == TAG_FRAME) |=> tx_sym != SYM_SPACE);
  p_bal_restarts_parity_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en && (tx_tag == TAG_BAL) |=> !q.par_odd);
  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_sym));
endmodule

// File: rtl/ptc_rx_checker.sv
module ptc_rx_checker
  import ptc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic [SYM_W-1:0] rx_sym,
  output logic             rx_viol
);
  logic have_q, have_d;
  logic neg_q, neg_d;
  logic viol_q, viol_d;
  logic is_mark;

  assign is_mark = (rx_sym == SYM_POS) || (rx_sym == SYM_NEG);

  always_comb begin
    have_d = have_q;
    neg_d  = neg_q;
    viol_d = viol_q;
    if (rx_en) begin
      if (is_mark) begin
        viol_d = have_q && ((rx_sym == SYM_NEG) == neg_q);
        neg_d  = (rx_sym == SYM_NEG);
        have_d = 1'b1;
      end else begin
        viol_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      neg_q  <= 1'b0;
      viol_q <= 1'b0;
    end else begin
      have_q <= have_d;
      neg_q  <= neg_d;
      viol_q <= viol_d;
    end
  end

  assign rx_viol = viol_q;

  p_space_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !is_mark |=> !rx_viol);
  p_hold_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(rx_viol));
  p_first_mark_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en && !have_q |=> !rx_viol);
endmodule

// File: rtl/ptc_line_codec.sv
module ptc_line_codec
  import ptc_pkg::*;
#(
  parameter bit FIRST_POS  = 1'b1,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             tx_bit,
  input  logic [TAG_W-1:0] tx_tag,
  output logic [SYM_W-1:0] tx_sym,
  input  logic             rx_en,
  input  logic [SYM_W-1:0] rx_sym,
  output logic             rx_viol
);
  logic rst_n_s;

  generate
    if (RST_STAGES <= 1) begin : g_rst_one
      logic rst_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= 1'b0;
        else        rst_q <= 1'b1;
      end
      assign rst_n_s = rst_q;
    end else begin : g_rst_chain
      logic [RST_STAGES-1:0] rst_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_q <= '0;
        else        rst_q <= {rst_q[RST_STAGES-2:0], 1'b1};
      end
      assign rst_n_s = rst_q[RST_STAGES-1];
    end
  endgenerate

  ptc_tx_encoder #(.FIRST_POS(FIRST_POS)) u_enc (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .bit_en (bit_en),
    .tx_bit (tx_bit),
    .tx_tag (tx_tag),
    .tx_sym (tx_sym)
  );

  ptc_rx_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .rx_en   (rx_en),
    .rx_sym  (rx_sym),
    .rx_viol (rx_viol)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_s |-> (tx_sym == SYM_SPACE) && !rx_viol);
endmodule

// File: tb/ptc_line_codec_test.sv
module ptc_line_codec_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en, tx_bit, rx_en;
  logic [1:0] tx_tag, rx_sym;
  logic [1:0] tx_sym;
  logic       rx_viol;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  ptc_line_codec uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit),
    .tx_tag(tx_tag), .tx_sym(tx_sym), .rx_en(rx_en), .rx_sym(rx_sym),
    .rx_viol(rx_viol)
  );

  // {tag[1:0], bit, expected symbol[1:0], expected rx flag}
  localparam logic [5:0] VEC [23] = '{
    6'b00_0_01_0, 6'b00_1_00_0, 6'b00_0_10_0, 6'b10_0_00_0,
    6'b00_0_01_0, 6'b10_0_10_0, 6'b01_1_10_1, 6'b10_0_01_0,
    6'b00_1_00_0, 6'b00_0_01_1, 6'b00_0_10_0, 6'b00_0_01_0,
    6'b10_0_10_0, 6'b01_0_10_1, 6'b10_0_01_0, 6'b00_0_01_1,
    6'b10_0_10_0, 6'b00_0_01_0, 6'b11_0_10_0, 6'b01_1_10_1,
    6'b10_0_01_0, 6'b10_0_00_0, 6'b00_0_10_0
  };

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [1:0] tag);
    case (tag)
      2'b01:   return "R3 frame-start";
      2'b10:   return "R4 balancing";
      2'b11:   return "R7 reserved tag";
      default: return "R2 R5 R6 data";
    endcase
  endfunction

  task automatic step(input logic en_t, input logic [1:0] tag, input logic b,
                      input logic en_r, input logic [1:0] rs);
    bit_en = en_t; tx_tag = tag; tx_bit = b; rx_en = en_r; rx_sym = rs;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; tx_bit = 1'b0; tx_tag = 2'b00;
    rx_en = 1'b0; rx_sym = 2'b00;
    repeat (3) @(negedge clk);
    chk("R1 reset tx", tx_sym, 2'b00);
    chk("R1 reset rx", {1'b0, rx_viol}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release tx", tx_sym, 2'b00);

    for (int i = 0; i < 23; i++) begin
      step(1'b1, VEC[i][5:4], VEC[i][3], 1'b1, VEC[i][2:1]);
      chk(req_of(VEC[i][5:4]), tx_sym, VEC[i][2:1]);
      chk("R9 checker flag", {1'b0, rx_viol}, {1'b0, VEC[i][0]});
    end

    // R8: idle bit_en keeps output and state (last mark negative)
    step(1'b0, 2'b00, 1'b0, 1'b0, 2'b10);
    step(1'b0, 2'b01, 1'b1, 1'b0, 2'b10);
    chk("R8 hold tx", tx_sym, 2'b10);
    step(1'b1, 2'b00, 1'b0, 1'b0, 2'b00);
    chk("R8 state held, next mark positive", tx_sym, 2'b01);

    // receive directed: last rx mark was negative
    step(1'b0, 2'b00, 1'b1, 1'b1, 2'b01);
    chk("R9 alternating mark clean", {1'b0, rx_viol}, 2'b00);
    step(1'b0, 2'b00, 1'b1, 1'b1, 2'b01);
    chk("R9 repeated positive flagged", {1'b0, rx_viol}, 2'b01);
    step(1'b0, 2'b00, 1'b1, 1'b0, 2'b10);
    step(1'b0, 2'b00, 1'b1, 1'b0, 2'b00);
    chk("R11 flag held while idle", {1'b0, rx_viol}, 2'b01);
    step(1'b0, 2'b00, 1'b1, 1'b1, 2'b11);
    chk("R10 code 11 clears flag", {1'b0, rx_viol}, 2'b00);
    step(1'b0, 2'b00, 1'b1, 1'b1, 2'b01);
    chk("R10 polarity kept across code 11", {1'b0, rx_viol}, 2'b01);
    step(1'b0, 2'b00, 1'b1, 1'b1, 2'b00);
    chk("R10 space clears flag", {1'b0, rx_viol}, 2'b00);
    step(1'b0, 2'b00, 1'b1, 1'b1, 2'b01);
    chk("R10 polarity kept across space", {1'b0, rx_viol}, 2'b01);

    // R1: reset in mid-stream restores start polarity
    rst_n = 1'b0;
    step(1'b0, 2'b00, 1'b1, 1'b0, 2'b00);
    chk("R1 mid reset tx", tx_sym, 2'b00);
    chk("R1 mid reset rx", {1'b0, rx_viol}, 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step(1'b1, 2'b00, 1'b0, 1'b1, 2'b01);
    chk("R1 first mark positive", tx_sym, 2'b01);
    chk("R9 first rx mark unflagged", {1'b0, rx_viol}, 2'b00);
    step(1'b1, 2'b00, 1'b0, 1'b1, 2'b01);
    chk("R2 alternation after reset", tx_sym, 2'b10);
    chk("R9 flag after reset", {1'b0, rx_viol}, 2'b01);

    finish_run();
  end
endmodule